// File: doc/BRIEF.md
# Grouped-Priority Interrupt Arbiter

This block chooses which pending interrupt line the processor takes next, and decides whether that line may interrupt the handler already running. Each line has a 4-bit priority value. A run-time grouping setting splits the value into two parts. The upper part is the preemption level. The lower part is a sub-priority that only orders requests waiting at the same time. For both parts, a smaller number means a more urgent request.

Selection is combinational over the pending lines. The result is registered into a one-cycle take strobe, which carries the winning line index and a flag saying whether the take nests on top of a running handler. The block keeps a small stack of the priorities of active handlers. It pushes onto the stack on every take and pops on every handler return. The stack top gives the active preemption level used for the next decision. The processor side clears a line's pending bit once it has seen the take strobe for that line.

Top module: `irq_group_arbiter`

## Requirements
- R1: After reset, take_o, preempt_o and active_vld_o are 0, win_id_o is 0 and active_lvl_o is 0.
- R2: With grouping value g (values 5, 6 and 7 act as 4), a line's preemption level is its 4-bit priority shifted right by 4-g. At g=0 every level is 0. active_lvl_o shows the level of the stack-top entry under the current grouping, and reads 0 when the stack is empty.
- R3: Among pending lines, the winner has the numerically smallest 4-bit priority, so the preemption level is compared first and the sub-priority second.
- R4: Among pending lines with equal priority, the line that has been pending for the most cycles wins, up to the saturation of a per-line 8-bit age count.
- R5: Among lines with equal priority that became pending in the same cycle, the lowest index wins.
- R6: While a handler is active, a pending line is taken only if its preemption level is strictly below the level of the stack top. A take made while a handler is active raises preempt_o together with take_o.
- R7: While no handler is active, the winning pending line is always taken, and preempt_o stays 0.
- R8: take_o goes high for exactly one cycle, one clock edge after the cycle in which the take was decided. It is never high in two consecutive cycles.
- R9: A take pushes the winner's priority onto the stack. A pulse on ret_i pops the stack, and the entry below becomes the active one.
- R10: No take is decided in a cycle where ret_i is high or the stack holds STACK_DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | N_LINES | Pending request per line |
| prio_i | input | 4*N_LINES | 4-bit priority per line; line i uses bits 4i+3..4i |
| group_i | input | 3 | Grouping value, 0..4 (5..7 act as 4) |
| ret_i | input | 1 | Return from the current handler (pops the stack) |
| take_o | output | 1 | One-cycle strobe: take the line on win_id_o |
| win_id_o | output | IDX_W | Index of the line taken |
| preempt_o | output | 1 | The take nests on an active handler |
| active_vld_o | output | 1 | At least one handler is active |
| active_lvl_o | output | 4 | Preemption level of the stack top |

## Verification
The hardest case to reach is the age tie-break. Two lines must hold equal priority and stay pending for different lengths of time, while something else keeps both from being taken. The directed stimulus gets there by first taking a line of the same preemption level. It then raises one line, waits a few cycles, raises a second line with a lower index, and only then returns from the handler, so that the older line with the higher index has to win. Stack saturation and grouping values 0 and 5..7 also need deliberate nesting sequences, and separate directed steps build those.

// File: rtl/irq_arb_pkg.sv
// Shared helpers for the grouped-priority interrupt arbiter.
// Assumes 4-bit priority values; grouping values above 4 act as 4.
package irq_arb_pkg;

    localparam int PRIO_W = 4;

    // Preemption level of a priority under a grouping value.
    function automatic logic [PRIO_W-1:0] preempt_level(input logic [PRIO_W-1:0] prio,
                                                        input logic [2:0] grp);
        int g;
        g = (grp > 3'd4) ? 4 : int'(grp);
        return prio >> (PRIO_W - g);
    endfunction

endpackage

// File: rtl/irq_age_track.sv
// Per-line age counters: each counts cycles while its line is pending and
// saturates; it clears when the line is not pending.
// Assumes pending inputs are synchronous to clk.
module irq_age_track #(
    parameter int N_LINES = 82,
    parameter int AGE_W   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_LINES-1:0]            pend_i,
    output logic [N_LINES-1:0][AGE_W-1:0] age_o
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        // Count pending cycles for line i, saturating at AGE_MAX.
        always_ff @(posedge clk) begin
            if (!rst_n)
                age_o[i] <= '0;
            else if (!pend_i[i])
                age_o[i] <= '0;
            else if (age_o[i] != AGE_MAX)
                age_o[i] <= age_o[i] + 1'b1;
        end
    end
endmodule

// File: rtl/irq_pick.sv
// Combinational winner search. The key is the priority followed by the
// inverted age, so lower priority first and then older requests win.
// A strict compare keeps the lowest index on a full tie.
module irq_pick #(
    parameter int N_LINES = 82,
    parameter int AGE_W   = 8,
    parameter int IDX_W   = 7
) (
    input  logic [N_LINES-1:0]            pend_i,
    input  logic [N_LINES*4-1:0]          prio_i,
    input  logic [N_LINES-1:0][AGE_W-1:0] age_i,
    output logic                          found_o,
    output logic [IDX_W-1:0]              id_o,
    output logic [3:0]                    prio_o
);
    localparam int KEY_W = 4 + AGE_W;

    logic [KEY_W-1:0] best_key;

    // Scan all lines and keep the smallest key among pending ones.
    always_comb begin
        found_o  = 1'b0;
        id_o     = '0;
        prio_o   = '0;
        best_key = '1;
        for (int i = 0; i < N_LINES; i++) begin
            if (pend_i[i] && (!found_o || {prio_i[i*4 +: 4], ~age_i[i]} < best_key)) begin
                found_o  = 1'b1;
                id_o     = IDX_W'(i);
                prio_o   = prio_i[i*4 +: 4];
                best_key = {prio_i[i*4 +: 4], ~age_i[i]};
            end
        end
    end
endmodule

// File: rtl/irq_nest_stack.sv
// Stack of the priorities of active handlers. push_i and pop_i are
// never both high; push_i is never high while full_o is high.
module irq_nest_stack #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  logic       pop_i,
    input  logic [3:0] data_i,
    output logic [3:0] top_o,
    output logic       vld_o,
    output logic       full_o
);
    localparam int SP_W = $clog2(DEPTH + 1);

    logic [3:0]      mem_q [DEPTH];
    logic [SP_W-1:0] sp_q;

    // Write the pushed entry and move the stack pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (push_i) begin
            mem_q[int'(sp_q)] <= data_i;
            sp_q              <= sp_q + 1'b1;
        end else if (pop_i && sp_q != '0) begin
            sp_q <= sp_q - 1'b1;
        end
    end

    // Present the top entry and the occupancy flags.
    always_comb begin
        vld_o  = (sp_q != '0);
        full_o = (int'(sp_q) == DEPTH);
        top_o  = vld_o ? mem_q[int'(sp_q) - 1] : 4'd0;
    end
endmodule

// File: rtl/irq_group_arbiter.sv
// Grouped-priority interrupt arbiter top. Picks the best pending line,
// checks it against the active preemption level and issues a registered
// one-cycle take. Assumes the requester clears a line's pending bit
// after seeing take_o for it, and ret_i marks handler return.
module irq_group_arbiter
    import irq_arb_pkg::*;
#(
    parameter int  N_LINES     = 82,
    parameter int  STACK_DEPTH = 16,
    parameter int  AGE_W       = 8,
    localparam int IDX_W       = $clog2(N_LINES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_LINES-1:0]     pend_i,
    input  logic [N_LINES*4-1:0]   prio_i,
    input  logic [2:0]             group_i,
    input  logic                   ret_i,
    output logic                   take_o,
    output logic [IDX_W-1:0]       win_id_o,
    output logic                   preempt_o,
    output logic                   active_vld_o,
    output logic [3:0]             active_lvl_o
);
    logic [N_LINES-1:0][AGE_W-1:0] age;
    logic             found;
    logic [IDX_W-1:0] win_id;
    logic [3:0]       win_prio;
    logic [3:0]       top_prio;
    logic             stk_vld;
    logic             stk_full;
    logic             take_now;

    irq_age_track #(.N_LINES(N_LINES), .AGE_W(AGE_W)) u_age (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .age_o(age)
    );

    irq_pick #(.N_LINES(N_LINES), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_pick (
        .pend_i(pend_i), .prio_i(prio_i), .age_i(age),
        .found_o(found), .id_o(win_id), .prio_o(win_prio)
    );

    irq_nest_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n),
        .push_i(take_now), .pop_i(ret_i && stk_vld), .data_i(win_prio),
        .top_o(top_prio), .vld_o(stk_vld), .full_o(stk_full)
    );

    // Decide whether the current winner is taken this cycle.
    always_comb begin
        take_now = found && !take_o && !ret_i && !stk_full &&
                   (!stk_vld || preempt_level(win_prio, group_i) < preempt_level(top_prio, group_i));
    end

    // Register the take strobe, the winner index and the nesting flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o    <= 1'b0;
            win_id_o  <= '0;
            preempt_o <= 1'b0;
        end else begin
            take_o    <= take_now;
            preempt_o <= take_now && stk_vld;
            if (take_now) win_id_o <= win_id;
        end
    end

    // Report the active handler state from the stack top.
    always_comb begin
        active_vld_o = stk_vld;
        active_lvl_o = stk_vld ? preempt_level(top_prio, group_i) : 4'd0;
    end
endmodule

// File: rtl/irq_group_arbiter_chk.sv
// Property checker for irq_group_arbiter, attached by bind.
// Observes ports only.
module irq_group_arbiter_chk #(
    parameter int N_LINES = 82,
    parameter int IDX_W   = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       group_i,
    input logic             ret_i,
    input logic             take_o,
    input logic [IDX_W-1:0] win_id_o,
    input logic             preempt_o,
    input logic             active_vld_o,
    input logic [3:0]       active_lvl_o
);
    // R8
    take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    // R10
    ret_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_i |=> !take_o);

    // R7
    preempt_only_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_o |-> take_o);

    // R9
    push_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> active_vld_o);

    // R6
    preempt_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && preempt_o && $stable(group_i)) |-> (active_lvl_o < $past(active_lvl_o)));

    // R6
    preempt_had_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && preempt_o) |-> $past(active_vld_o));

    // R2
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_vld_o |-> (active_lvl_o == 4'd0));
endmodule

bind irq_group_arbiter irq_group_arbiter_chk #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .group_i(group_i), .ret_i(ret_i),
    .take_o(take_o), .win_id_o(win_id_o), .preempt_o(preempt_o),
    .active_vld_o(active_vld_o), .active_lvl_o(active_lvl_o)
);

// File: tb/irq_group_arbiter_bench.sv
// Bench: directed corner cases plus seeded random traffic, compared
// against a cycle model built from the requirements.
module irq_group_arbiter_bench;
    localparam int N  = 82;
    localparam int D  = 4;
    localparam int IW = $clog2(N);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic [N-1:0]  pend;
    logic [3:0]    pr [N];
    logic [N*4-1:0] prio_flat;
    logic [2:0]    group;
    logic          ret;
    logic          take_o, preempt_o, active_vld_o;
    logic [IW-1:0] win_id_o;
    logic [3:0]    active_lvl_o;

    always_comb for (int i = 0; i < N; i++) prio_flat[i*4 +: 4] = pr[i];

    irq_group_arbiter #(.N_LINES(N), .STACK_DEPTH(D), .AGE_W(8)) u_irq_group_arbiter (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .prio_i(prio_flat), .group_i(group),
        .ret_i(ret), .take_o(take_o), .win_id_o(win_id_o), .preempt_o(preempt_o),
        .active_vld_o(active_vld_o), .active_lvl_o(active_lvl_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    int       m_age [N];
    logic [3:0] m_stk [D];
    int       m_sp = 0;
    bit       m_tq = 0;

    function automatic int lvl(input logic [3:0] p, input logic [2:0] g);
        int gg = (g > 3'd4) ? 4 : int'(g);
        return int'(p >> (4 - gg));
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: predict, advance the model, compare at the falling edge.
    task automatic tick();
        int best = -1;
        bit el;
        for (int i = 0; i < N; i++) begin
            if (pend[i] && (best < 0 || pr[i] < pr[best] ||
                (pr[i] == pr[best] && m_age[i] > m_age[best]))) best = i;
        end
        el = (best >= 0) && !m_tq && !ret && (m_sp < D) &&
             (m_sp == 0 || lvl(pr[best], group) < lvl(m_stk[m_sp-1], group));
        @(posedge clk);
        if (el) begin
            m_stk[m_sp] = pr[best];
            m_sp++;
        end else if (ret && m_sp > 0) begin
            m_sp--;
        end
        for (int i = 0; i < N; i++) m_age[i] = pend[i] ? ((m_age[i] < 255) ? m_age[i] + 1 : 255) : 0;
        @(negedge clk);
        chk(int'(take_o), int'(el), "R8 take strobe");
        if (el) begin
            chk(int'(win_id_o), best, "R3 winner index");
            chk(int'(preempt_o), int'(m_sp > 1), "R6 preempt flag");
        end else begin
            chk(int'(preempt_o), 0, "R7 preempt idle");
        end
        chk(int'(active_vld_o), int'(m_sp > 0), "R9 active valid");
        chk(int'(active_lvl_o), (m_sp > 0) ? lvl(m_stk[m_sp-1], group) : 0, "R2 active level");
        m_tq = el;
        if (el) pend[best] = 1'b0;
    endtask

    task automatic drain();
        pend = '0;
        ret  = 1'b1;
        repeat (D + 2) tick();
        ret = 1'b0;
        tick();
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; pend = '0; group = 3'd2; ret = 1'b0;
        for (int i = 0; i < N; i++) begin pr[i] = 4'hF; m_age[i] = 0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(int'(take_o), 0, "R1 take");
        chk(int'(preempt_o), 0, "R1 preempt");
        chk(int'(active_vld_o), 0, "R1 active valid");
        chk(int'(win_id_o), 0, "R1 win id");
        chk(int'(active_lvl_o), 0, "R1 active level");
        rst_n = 1'b1;

        // R3 R7: group 2, lines 7 (2/0), 3 (2/1), 6 (3/0)
        pr[7] = 4'd8; pr[3] = 4'd9; pr[6] = 4'd12;
        pend[7] = 1; pend[3] = 1; pend[6] = 1;
        tick();
        chk(int'(take_o), 1, "R3 take");
        chk(int'(win_id_o), 7, "R3 best line");
        chk(int'(preempt_o), 0, "R7 no nest when idle");
        tick();
        chk(int'(take_o), 0, "R8 gap after take");
        tick();
        chk(int'(take_o), 0, "R6 equal level blocked");
        chk(int'(active_lvl_o), 2, "R2 level under group 2");

        // R6 strict preemption
        pr[10] = 4'd4; pend[10] = 1;
        tick();
        chk(int'(take_o), 1, "R6 higher level preempts");
        chk(int'(win_id_o), 10, "R6 preempting line");
        chk(int'(preempt_o), 1, "R6 preempt flag");
        tick();

        // R9 R10 return sequence
        ret = 1; tick();
        chk(int'(take_o), 0, "R10 return blocks take");
        chk(int'(active_lvl_o), 2, "R9 pop reveals lower entry");
        ret = 0; tick();
        ret = 1; tick();
        chk(int'(active_vld_o), 0, "R9 stack empty");
        ret = 0; tick();
        chk(int'(win_id_o), 3, "R7 idle take of line 3");
        tick();
        ret = 1; tick(); ret = 0; tick();
        chk(int'(win_id_o), 6, "R3 last pending line");
        drain();

        // R5 same-cycle tie, then R4 age ordering
        pr[20] = 4'd5; pr[21] = 4'd5; pend[20] = 1; pend[21] = 1;
        tick();
        chk(int'(win_id_o), 20, "R5 lower index on tie");
        pr[30] = 4'd5; pend[30] = 1; tick(); tick();
        pr[25] = 4'd5; pend[25] = 1; tick();
        pend[21] = 0; tick();
        ret = 1; tick(); ret = 0; tick();
        chk(int'(take_o), 1, "R4 take after return");
        chk(int'(win_id_o), 30, "R4 older line wins");
        drain();

        // R2 grouping 7 acts as 4; grouping 0 never nests
        group = 3'd7; pr[40] = 4'd3; pend[40] = 1; tick(); tick();
        pr[41] = 4'd2; pend[41] = 1; tick();
        chk(int'(preempt_o), 1, "R2 group 7 acts as 4");
        drain();
        group = 3'd0; pr[42] = 4'd3; pend[42] = 1; tick(); tick();
        pr[43] = 4'd0; pend[43] = 1; tick(); tick();
        chk(int'(take_o), 0, "R2 group 0 no preemption");
        drain();

        // R10 full stack
        group = 3'd4;
        for (int k = 0; k < 5; k++) begin
            pr[50 + k] = 4'(8 - k); pend[50 + k] = 1; tick(); tick();
        end
        chk(int'(active_lvl_o), 5, "R10 full stack keeps top");
        chk(int'(pend[54]), 1, "R10 line held while full");
        drain();

        // Random traffic
        for (int c = 0; c < 3000; c++) begin
            if (c % 300 == 0) begin
                for (int i = 0; i < N; i++) pr[i] = 4'($urandom % 16);
                group = 3'($urandom % 8);
            end
            if ($urandom % 8 == 0) pend[$urandom % N] = 1'b1;
            ret = (m_sp > 0) && ($urandom % 6 == 0);
            tick();
        end
        drain();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule